// File: doc/BRIEF.md
# Banked GPIO Controller with Alternate-Function Select

This block drives and samples up to 64 general-purpose pins through a word-addressed register port. Pins are packed 32 to a bank, and every register group repeats once per bank. The word for a pin therefore sits at a byte address built from the group's base and the pin's bank. Software can set or clear output bits without a read-modify-write, rewrite the output latch directly, read the synchronised pin level, choose per pin whether the pad is driven, and pick one of four functions per pin (0 is plain GPIO).

Each synchronised input feeds a sticky pending bit. In edge mode a pending bit records any change of the input. In level mode it records a high input, and it keeps reasserting for as long as the input stays high. An enable word masks the pending bits. The masked view can be read back, and its OR drives a single interrupt line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads 0, so all pins are GPIO inputs (pinOe=0, pinFunc=0, pinOut=0) and irqOut is 0.
- R2: A write to group 0 (set) sets the output bits where the data has ones. A write to group 1 (clear) clears them. Zero data bits leave outputs unchanged. Writing group 2 replaces the output latch word, and reading group 2 returns the latch. Groups 0 and 1 read as 0.
- R3: With BANKS = 1 + (NPINS-1)/32, group g (0..11) for bank b is at byte address 4*(g*BANKS + b). Pin p lives in bank p/32 at bit p%32. The low two address bits are ignored.
- R4: Reading group 3 returns the pin level after a two-flop synchroniser. A change on pinIn is visible on the second rising edge. A 1 in group 4 makes the pin an output (pinOe).
- R5: The function index of pin p is {group9 bit, group8 bit} at the pin's bit position, presented on pinFunc[2p+1:2p].
- R6: With the pin's group 11 bit at 0 (edge mode), any change of the synchronised input sets the pin's pending bit (group 5). The bit appears on the third rising edge after pinIn changes.
- R7: With the pin's group 11 bit at 1 (level mode), the pending bit sets on every cycle the synchronised input is high, so it reasserts after being cleared while the input stays high.
- R8: Writing ones to group 5 clears those pending bits. A pending event in the same cycle wins over the clear.
- R9: Group 7 reads the pending bits ANDed with the enable bits (group 6). irqOut is the OR of those bits over all banks.
- R10: Bits at or above NPINS read 0 and ignore writes. Writes to groups 3, 7 and 10, and to addresses past group 11, change nothing. Group 10 and addresses past group 11 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr (combinational) |
| pinIn | input | NPINS | Raw pin levels |
| pinOut | output | NPINS | Output latch |
| pinOe | output | NPINS | Per-pin output enable |
| pinFunc | output | 2*NPINS | Per-pin function index, two bits per pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a pending event and a write-one-to-clear landing on the same bit in the same clock. Edge events last a single cycle, three edges after the pin moves, so lining them up with a register write is fragile. The stimulus puts a pin in level mode and holds its input high, which produces an event on every cycle. Any clear write then collides with an event, and the pending bit must read back still set right after the write. Edge-mode pins held steady are cleared in the same way and must stay cleared. This gives the contrast between the two modes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GRP_COUNT = 12;

  typedef enum logic [3:0] {
    GRP_OSET  = 4'd0,
    GRP_OCLR  = 4'd1,
    GRP_OUT   = 4'd2,
    GRP_IN    = 4'd3,
    GRP_OE    = 4'd4,
    GRP_PEND  = 4'd5,
    GRP_ENA   = 4'd6,
    GRP_IDENT = 4'd7,
    GRP_FSEL0 = 4'd8,
    GRP_FSEL1 = 4'd9,
    GRP_RSVD  = 4'd10,
    GRP_TRIG  = 4'd11
  } grp_e;

  typedef struct packed {
    logic [GRP_COUNT-1:0] wrStb;
    logic                 bankSel;
    grp_e                 rdGrp;
    logic                 rdHit;
  } gpio_stb_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS  = 40,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output gpio_stb_t         stb
);
  localparam int BANKS  = 1 + (NPINS - 1) / 32;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic [WORD_W-1:0] grpIdx;
  logic              bankIdx;
  logic              mapped;
  logic              writable;

  assign wordIdx = regAddr[ADDR_W-1:2];

  generate
    if (BANKS == 1) begin : g_one_bank
      assign grpIdx  = wordIdx;
      assign bankIdx = 1'b0;
    end else begin : g_two_banks
      assign grpIdx  = {1'b0, wordIdx[WORD_W-1:1]};
      assign bankIdx = wordIdx[0];
    end
  endgenerate

  always_comb begin
    mapped   = (grpIdx < WORD_W'(GRP_COUNT)) && (grpIdx != WORD_W'(GRP_RSVD));
    writable = mapped && (grpIdx != WORD_W'(GRP_IN)) && (grpIdx != WORD_W'(GRP_IDENT));
    stb         = '0;
    stb.rdHit   = mapped;
    stb.rdGrp   = grp_e'(grpIdx[3:0]);
    stb.bankSel = bankIdx;
    for (int g = 0; g < GRP_COUNT; g++)
      stb.wrStb[g] = wrEn && writable && (grpIdx == WORD_W'(g));
  end

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.wrStb));
  p_no_write_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (stb.wrStb == '0));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NPINS = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  gpio_stb_t          stb,
  input  logic [31:0]        wrData,
  input  logic [NPINS-1:0]   pinIn,
  output logic [31:0]        rdData,
  output logic [NPINS-1:0]   pinOut,
  output logic [NPINS-1:0]   pinOe,
  output logic [2*NPINS-1:0] pinFunc,
  output logic               irqOut
);
  localparam int BANKS = 1 + (NPINS - 1) / 32;
  localparam int W     = BANKS * 32;
  localparam logic [W-1:0] VMASK = (W'(1) << NPINS) - W'(1);

  logic [W-1:0] bankMask, fieldMask, wrMask, evtV, clrV, inPad, wordSel;
  logic [W-1:0] syncA, syncB, syncC;
  logic [W-1:0] outReg, oeReg, pendReg, enaReg, alt0Reg, alt1Reg, trigReg;

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign bankMask[b*32 +: 32] = {32{stb.bankSel == 1'(b)}};
    end
  endgenerate

  assign inPad     = W'(pinIn);
  assign fieldMask = bankMask & VMASK;
  assign wrMask    = {BANKS{wrData}} & fieldMask;
  assign evtV      = ((trigReg & syncB) | (~trigReg & (syncB ^ syncC))) & VMASK;
  assign clrV      = stb.wrStb[GRP_PEND] ? wrMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; syncC <= '0;
      outReg <= '0; oeReg <= '0; pendReg <= '0; enaReg <= '0;
      alt0Reg <= '0; alt1Reg <= '0; trigReg <= '0;
    end else begin
      syncA <= inPad;
      syncB <= syncA;
      syncC <= syncB;
      if (stb.wrStb[GRP_OSET])      outReg <= outReg | wrMask;
      else if (stb.wrStb[GRP_OCLR]) outReg <= outReg & ~wrMask;
      else if (stb.wrStb[GRP_OUT])  outReg <= (outReg & ~fieldMask) | wrMask;
      if (stb.wrStb[GRP_OE])    oeReg   <= (oeReg   & ~fieldMask) | wrMask;
      if (stb.wrStb[GRP_ENA])   enaReg  <= (enaReg  & ~fieldMask) | wrMask;
      if (stb.wrStb[GRP_FSEL0]) alt0Reg <= (alt0Reg & ~fieldMask) | wrMask;
      if (stb.wrStb[GRP_FSEL1]) alt1Reg <= (alt1Reg & ~fieldMask) | wrMask;
      if (stb.wrStb[GRP_TRIG])  trigReg <= (trigReg & ~fieldMask) | wrMask;
      pendReg <= (pendReg & ~clrV) | evtV;
    end
  end

  always_comb begin
    case (stb.rdGrp)
      GRP_OUT:   wordSel = outReg;
      GRP_IN:    wordSel = syncB;
      GRP_OE:    wordSel = oeReg;
      GRP_PEND:  wordSel = pendReg;
      GRP_ENA:   wordSel = enaReg;
      GRP_IDENT: wordSel = pendReg & enaReg;
      GRP_FSEL0: wordSel = alt0Reg;
      GRP_FSEL1: wordSel = alt1Reg;
      GRP_TRIG:  wordSel = trigReg;
      default:   wordSel = '0;
    endcase
    rdData = '0;
    for (int b = 0; b < BANKS; b++)
      if (stb.rdHit && (stb.bankSel == 1'(b))) rdData = wordSel[b*32 +: 32];
  end

  assign pinOut = outReg[NPINS-1:0];
  assign pinOe  = oeReg[NPINS-1:0];
  assign irqOut = |(pendReg & enaReg);

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_func
      assign pinFunc[2*p +: 2] = {alt1Reg[p], alt0Reg[p]};
    end
  endgenerate

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb[GRP_OSET] |=> ((outReg & $past(wrMask)) == $past(wrMask)));
  p_clear_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb[GRP_OCLR] |=> ((outReg & $past(wrMask)) == '0));
  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|evtV) |=> ((pendReg & $past(evtV)) == $past(evtV)));
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb[GRP_PEND] |=> ((pendReg & $past(wrMask & ~evtV)) == '0));
  p_high_bits_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((outReg | oeReg | pendReg | enaReg | alt0Reg | alt1Reg | trigReg) & ~VMASK) == '0);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS  = 40,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NPINS-1:0]   pinIn,
  output logic [NPINS-1:0]   pinOut,
  output logic [NPINS-1:0]   pinOe,
  output logic [2*NPINS-1:0] pinFunc,
  output logic               irqOut
);
  gpio_stb_t stb;

  gpio_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .stb(stb)
  );

  gpio_datapath #(.NPINS(NPINS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .pinIn(pinIn),
    .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe), .pinFunc(pinFunc),
    .irqOut(irqOut)
  );
endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
  localparam int NP = 40;
  localparam int ST = 2;

  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0;
  logic [7:0] regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic [2*NP-1:0] pinFunc;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NPINS(NP), .ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .pinFunc(pinFunc), .irqOut(irqOut)
  );

  // behavioural reference state, one bit per pin
  logic [63:0] mOut, mOe, mPend, mEna, mA0, mA1, mTrig, mS1, mS2, mS3, mEvt;

  function automatic int adr(int g, int b);
    return (g * ST + b) * 4;
  endfunction

  function automatic logic [31:0] mRead(logic [7:0] a);
    int g = (a >> 2) / ST;
    int b = (a >> 2) % ST;
    logic [31:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      if (p / 32 == b) begin
        case (g)
          2:  r[p%32] = mOut[p];
          3:  r[p%32] = mS2[p];
          4:  r[p%32] = mOe[p];
          5:  r[p%32] = mPend[p];
          6:  r[p%32] = mEna[p];
          7:  r[p%32] = mPend[p] & mEna[p];
          8:  r[p%32] = mA0[p];
          9:  r[p%32] = mA1[p];
          11: r[p%32] = mTrig[p];
          default: r[p%32] = 1'b0;
        endcase
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOut = '0; mOe = '0; mPend = '0; mEna = '0; mA0 = '0; mA1 = '0;
      mTrig = '0; mS1 = '0; mS2 = '0; mS3 = '0;
    end else begin
      for (int p = 0; p < NP; p++)
        mEvt[p] = mTrig[p] ? mS2[p] : (mS2[p] ^ mS3[p]);
      if (wrEn) begin
        for (int p = 0; p < NP; p++) begin
          if (p / 32 == (regAddr >> 2) % ST) begin
            case ((regAddr >> 2) / ST)
              0:  if (wrData[p%32]) mOut[p] = 1'b1;
              1:  if (wrData[p%32]) mOut[p] = 1'b0;
              2:  mOut[p] = wrData[p%32];
              4:  mOe[p] = wrData[p%32];
              5:  if (wrData[p%32]) mPend[p] = 1'b0;
              6:  mEna[p] = wrData[p%32];
              8:  mA0[p] = wrData[p%32];
              9:  mA1[p] = wrData[p%32];
              11: mTrig[p] = wrData[p%32];
              default: ;
            endcase
          end
        end
      end
      for (int p = 0; p < NP; p++) begin
        if (mEvt[p]) mPend[p] = 1'b1;
        mS3[p] = mS2[p];
        mS2[p] = mS1[p];
        mS1[p] = pinIn[p];
      end
    end
  end

  // outputs compared with the model on every clock
  always @(negedge clk) begin
    if (!done) begin
      logic [2*NP-1:0] eFunc;
      for (int p = 0; p < NP; p++) eFunc[2*p +: 2] = {mA1[p], mA0[p]};
      checks += 4;
      if (pinOut !== mOut[NP-1:0]) begin
        errors++; $display("FAIL R2 pinOut act=%h exp=%h", pinOut, mOut[NP-1:0]);
      end
      if (pinOe !== mOe[NP-1:0]) begin
        errors++; $display("FAIL R4 pinOe act=%h exp=%h", pinOe, mOe[NP-1:0]);
      end
      if (pinFunc !== eFunc) begin
        errors++; $display("FAIL R5 pinFunc act=%h exp=%h", pinFunc, eFunc);
      end
      if (irqOut !== |(mPend & mEna)) begin
        errors++; $display("FAIL R9 irqOut act=%b exp=%b", irqOut, |(mPend & mEna));
      end
    end
  end

  task automatic chk(logic [63:0] act, logic [63:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1; regAddr = 8'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  // called right after a falling edge; compares with model and a literal
  task automatic rdNow(int a, logic [31:0] exp, string tag);
    regAddr = 8'(a);
    #1;
    chk(64'(rdData), 64'(exp), tag);
    chk(64'(rdData), 64'(mRead(8'(a))), {tag, " model"});
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    rdNow(a, exp, tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    // R1: reset state
    for (int g = 0; g < 12; g++)
      for (int b = 0; b < ST; b++) rd(adr(g, b), 32'h0, "R1 reset read");
    chk(64'(irqOut), 64'h0, "R1 irq after reset");

    // R2: set / clear / direct latch write
    wr(adr(0, 0), 32'h0000_00F5);
    wr(adr(1, 0), 32'h0000_0014);
    rd(adr(2, 0), 32'h0000_00E1, "R2 set then clear");
    rd(adr(0, 0), 32'h0, "R2 set group reads zero");
    wr(adr(0, 1), 32'hFFFF_FFFF);
    rd(adr(2, 1), 32'h0000_00FF, "R10 bank1 out upper bits");
    wr(adr(2, 0), 32'h1234_5678);
    rd(adr(2, 0), 32'h1234_5678, "R2 direct latch write");
    chk(64'(pinOut), 64'hFF_1234_5678, "R3 bank interleave");

    // R4: output enable
    wr(adr(4, 0), 32'h0000_00A5);
    chk(64'(pinOe), 64'hA5, "R4 oe pins");

    // R5: function select split over two bit planes
    wr(adr(8, 0), 32'h3);
    wr(adr(9, 0), 32'h6);
    chk(64'(pinFunc[5:0]), 64'h2D, "R5 function index");

    // R4: input synchroniser latency
    @(negedge clk);
    pinIn = 40'h81_0000_0003;
    @(negedge clk); rdNow(adr(3, 0), 32'h0, "R4 in after one edge");
    @(negedge clk); rdNow(adr(3, 0), 32'h3, "R4 in after two edges");
    rd(adr(3, 1), 32'h81, "R4 in bank1");
    idle(2);

    // R6: edge interrupt on pin 4
    wr(adr(5, 0), 32'hFFFF_FFFF);
    wr(adr(5, 1), 32'hFFFF_FFFF);
    rd(adr(5, 0), 32'h0, "R8 all cleared");
    wr(adr(6, 0), 32'h10);
    @(negedge clk);
    pinIn[4] = 1'b1;
    idle(2);
    chk(64'(irqOut), 64'h0, "R6 not yet after two edges");
    @(negedge clk);
    chk(64'(irqOut), 64'h1, "R6 irq on third edge");
    rdNow(adr(7, 0), 32'h10, "R9 ident rise");
    wr(adr(5, 0), 32'h10);
    rdNow(adr(5, 0), 32'h0, "R8 edge pin stays cleared");
    chk(64'(irqOut), 64'h0, "R9 irq drops");
    @(negedge clk);
    pinIn[4] = 1'b0;
    idle(3);
    rdNow(adr(7, 0), 32'h10, "R6 falling edge");
    wr(adr(5, 0), 32'h10);

    // R7: level mode on pin 8, with set winning over clear
    wr(adr(11, 0), 32'h100);
    wr(adr(6, 0), 32'h110);
    @(negedge clk);
    pinIn[8] = 1'b1;
    idle(4);
    rdNow(adr(7, 0), 32'h100, "R7 level pending");
    wr(adr(5, 0), 32'h100);
    rdNow(adr(5, 0), 32'h100, "R8 event wins over clear");
    idle(2);
    rdNow(adr(5, 0), 32'h100, "R7 reasserts while high");
    pinIn[8] = 1'b0;
    idle(3);
    wr(adr(5, 0), 32'h100);
    rdNow(adr(5, 0), 32'h0, "R7 low level stays clear");

    // R10: ignored writes
    wr(adr(3, 0), 32'hFFFF_FFFF);
    wr(adr(7, 0), 32'hFFFF_FFFF);
    wr(adr(10, 0), 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(adr(4, 0), 32'hA5, "R10 oe untouched");
    rd(adr(10, 0), 32'h0, "R10 reserved reads zero");
    rd(8'h60, 32'h0, "R10 past end reads zero");
    rd(adr(6, 0), 32'h110, "R10 enable untouched");
    wr(adr(6, 1), 32'hFFFF_FFFF);
    rd(adr(6, 1), 32'hFF, "R10 enable upper bits");

    // R9: bank1 interrupt on pin 35
    wr(adr(5, 1), 32'hFFFF_FFFF);
    @(negedge clk);
    pinIn[35] = 1'b1;
    idle(3);
    chk(64'(irqOut), 64'h1, "R9 bank1 irq");
    rdNow(adr(7, 1), 32'h8, "R9 bank1 ident");
    rdNow(adr(7, 0), 32'h0, "R9 bank0 ident idle");
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule